// File: doc/BRIEF.md
# Hold-Flag Block Scan Decoder

This block is a decompression stage placed between a serial pseudo-random bit source and the scan-in pin of a scan chain. Its purpose is to lower toggling in the chain during shift. Each scan load is split into fixed-size blocks. On the source stream, every block is preceded by a single control bit, the hold flag.

When the flag is 0, the block is a transition block. Its data bits are copied from the source to the scan input. When the flag is 1, the scan input is frozen for the whole block. The frozen value is the last bit sent to the chain, or 0 if the block opens a new pattern. The source still delivers the block's data bits in a held block, but those bits are consumed and ignored.

The flag bit is never shifted into the chain. The source may pause at any time by dropping its valid signal. The scan length must be a whole multiple of the block size.

Top module: `hold_block_decoder`

## Requirements
- R1: During and directly after synchronous reset, `scan_en` is 0 and `scan_do` is 0, and the first valid source bit is taken as a hold flag.
- R2: The flag bit of each block is consumed from the source without producing a `scan_en` pulse.
- R3: In a block whose flag is 0, each valid data bit appears on `scan_do`, with `scan_en` = 1, one clock after it is accepted.
- R4: In a block whose flag is 1, every one of its BLK_BITS outputs equals the last bit sent to the chain before the block began, whatever the source's data bits are.
- R5: Each block uses exactly 1 + BLK_BITS valid source bits and produces exactly BLK_BITS `scan_en` pulses, after which the next valid bit is again read as a flag.
- R6: After SCAN_LEN bits have been shifted out (one pattern), the held value returns to 0, so a held first block of the next pattern shifts all zeros.
- R7: A cycle with `src_valid` = 0 consumes nothing, leaves the block position unchanged, and gives `scan_en` = 0 one clock later.
- R8: `scan_do` keeps its value in every cycle where `scan_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_bit | input | 1 | Serial bit from the pseudo-random source (flag or data) |
| src_valid | input | 1 | High when `src_bit` carries a bit to consume this cycle |
| scan_do | output | 1 | Registered scan-in data for the chain |
| scan_en | output | 1 | Registered shift enable; high when `scan_do` carries a new bit |

## Verification
The case that most needs care is the last data bit of the last block of a pattern. On that bit, the shift of that bit and the clearing of the held value for the next pattern happen on the same clock edge. To provoke it, the bench ends patterns with a transition block whose last bit is 1, and then opens the next pattern with a held block. The checks then expect zeros, not the 1 that was just shifted. A held block with varying source data also has to share that edge with the flag read that follows it; this is judged by the output of the next block.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef enum logic {
    ST_FLAG = 1'b0,
    ST_DATA = 1'b1
  } hbd_state_e;
endpackage

// File: rtl/hbd_ctrl.sv
// Block sequencer: reads the hold flag, then counts data bits in the block and blocks in the pattern.
module hbd_ctrl #(
  parameter int BLK_BITS     = 4,
  parameter int BLKS_PER_PAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic src_valid,
  input  logic src_bit,
  output logic flag_phase,
  output logic shift_now,
  output logic hold_sel,
  output logic pat_end
);
  import hbd_pkg::*;

  localparam int BW = $clog2(BLK_BITS + 1);
  localparam int PW = $clog2(BLKS_PER_PAT + 1);

  hbd_state_e     state_q;
  logic [BW-1:0]  bit_q;
  logic [PW-1:0]  blk_q;
  logic           flag_q;
  logic           last_bit;
  logic           last_blk;

  assign flag_phase = (state_q == ST_FLAG);
  assign shift_now  = src_valid && (state_q == ST_DATA);
  assign hold_sel   = flag_q;
  assign last_bit   = (bit_q == BW'(BLK_BITS - 1));
  assign last_blk   = (blk_q == PW'(BLKS_PER_PAT - 1));
  assign pat_end    = shift_now && last_bit && last_blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FLAG;
      bit_q   <= '0;
      blk_q   <= '0;
      flag_q  <= 1'b0;
    end else if (src_valid) begin
      case (state_q)
        ST_FLAG: begin
          flag_q  <= src_bit;
          bit_q   <= '0;
          state_q <= ST_DATA;
        end
        default: begin
          if (last_bit) begin
            state_q <= ST_FLAG;
            blk_q   <= last_blk ? '0 : blk_q + PW'(1);
          end else begin
            bit_q <= bit_q + BW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/hbd_datapath.sv
// Output stage: chooses the source bit or the held value, and registers the scan outputs.
module hbd_datapath (
  input  logic clk,
  input  logic rst,
  input  logic shift_now,
  input  logic hold_sel,
  input  logic src_bit,
  input  logic pat_end,
  output logic scan_do,
  output logic scan_en,
  output logic hold_q
);
  logic out_bit;

  assign out_bit = hold_sel ? hold_q : src_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_do <= 1'b0;
      scan_en <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      scan_en <= shift_now;
      if (shift_now) scan_do <= out_bit;
      if (pat_end)        hold_q <= 1'b0;
      else if (shift_now) hold_q <= out_bit;
    end
  end
endmodule

// File: rtl/hold_block_decoder.sv
module hold_block_decoder #(
  parameter int BLK_BITS = 4,
  parameter int SCAN_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic src_bit,
  input  logic src_valid,
  output logic scan_do,
  output logic scan_en
);
  localparam int BLKS_PER_PAT = SCAN_LEN / BLK_BITS;

  logic flag_phase;
  logic shift_now;
  logic hold_sel;
  logic pat_end;
  logic hold_q;

  hbd_ctrl #(
    .BLK_BITS     (BLK_BITS),
    .BLKS_PER_PAT (BLKS_PER_PAT)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .src_valid  (src_valid),
    .src_bit    (src_bit),
    .flag_phase (flag_phase),
    .shift_now  (shift_now),
    .hold_sel   (hold_sel),
    .pat_end    (pat_end)
  );

  hbd_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .shift_now (shift_now),
    .hold_sel  (hold_sel),
    .src_bit   (src_bit),
    .pat_end   (pat_end),
    .scan_do   (scan_do),
    .scan_en   (scan_en),
    .hold_q    (hold_q)
  );
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker #(
  parameter int SCAN_LEN = 16
) (
  input logic clk,
  input logic rst,
  input logic src_valid,
  input logic src_bit,
  input logic scan_do,
  input logic scan_en,
  input logic flag_phase,
  input logic hold_sel,
  input logic hold_q
);
  localparam int CW = $clog2(SCAN_LEN + 1);
  logic [CW-1:0] shifted_q;

  always_ff @(posedge clk) begin
    if (rst) shifted_q <= '0;
    else if (scan_en) shifted_q <= (shifted_q == CW'(SCAN_LEN - 1)) ? '0 : shifted_q + CW'(1);
  end

  // R1
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!scan_en && !scan_do));
  // R2
  a_r2_flag_no_shift: assert property (@(posedge clk) disable iff (rst)
    (flag_phase && src_valid) |=> !scan_en);
  // R3
  a_r3_pass_through: assert property (@(posedge clk) disable iff (rst)
    (!flag_phase && src_valid && !hold_sel) |=> (scan_en && scan_do == $past(src_bit)));
  // R4
  a_r4_held_value: assert property (@(posedge clk) disable iff (rst)
    (!flag_phase && src_valid && hold_sel) |=> (scan_en && scan_do == $past(hold_q)));
  // R6
  a_r6_pattern_clear: assert property (@(posedge clk) disable iff (rst)
    (scan_en && shifted_q == CW'(SCAN_LEN - 1)) |-> !hold_q);
  // R7
  a_r7_idle_no_shift: assert property (@(posedge clk) disable iff (rst)
    !src_valid |=> !scan_en);
  // R8
  a_r8_stable_when_idle: assert property (@(posedge clk) disable iff (rst)
    !src_valid |=> $stable(scan_do));
endmodule

bind hold_block_decoder hbd_checker #(.SCAN_LEN(SCAN_LEN)) u_hbd_chk (
  .clk        (clk),
  .rst        (rst),
  .src_valid  (src_valid),
  .src_bit    (src_bit),
  .scan_do    (scan_do),
  .scan_en    (scan_en),
  .flag_phase (flag_phase),
  .hold_sel   (hold_sel),
  .hold_q     (hold_q)
);

// File: tb/hold_block_decoder_bench.sv
module hold_block_decoder_bench;
  localparam int BLK = 4;
  localparam int SLEN = 16;
  localparam int BPP = SLEN / BLK;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_bit = 1'b0;
  logic src_valid = 1'b0;
  logic scan_do;
  logic scan_en;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int popped = 0;
  int cycles = 0;

  logic exp_bit_q[$];
  int   exp_tag_q[$];

  logic m_last = 1'b0;
  int   m_blk = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic prev_do = 1'b0;

  always #5 clk = ~clk;

  hold_block_decoder #(.BLK_BITS(BLK), .SCAN_LEN(SLEN)) u_hold_block_decoder (
    .clk(clk), .rst(rst), .src_bit(src_bit), .src_valid(src_valid),
    .scan_do(scan_do), .scan_en(scan_en)
  );

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles (expected completion)", cycles);
      finish_run();
    end
  end

  // Monitor: pop an expected bit for every scan_en pulse (R3, R4, R6) and check stability otherwise (R8).
  always @(negedge clk) begin
    if (!rst) begin
      if (scan_en) begin
        checks++;
        if (exp_bit_q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected scan_en pulse: actual 1 expected 0");
        end else begin
          logic e; int t;
          e = exp_bit_q.pop_front();
          t = exp_tag_q.pop_front();
          popped++;
          if (scan_do !== e) begin
            errors++;
            $display("FAIL R%0d scan_do bit %0d: actual %b expected %b", t, popped, scan_do, e);
          end
        end
      end else begin
        checks++;
        if (scan_do !== prev_do) begin
          errors++;
          $display("FAIL R8 scan_do changed without scan_en: actual %b expected %b", scan_do, prev_do);
        end
      end
      prev_do = scan_do;
    end
  end

  task automatic next_rand(output logic b);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    b = lfsr[0];
  endtask

  // R7: idle cycles before a bit; from the second idle cycle on, scan_en must be low.
  task automatic send_bit(input logic b, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      if (g > 0) begin
        checks++;
        if (scan_en !== 1'b0) begin
          errors++;
          $display("FAIL R7 scan_en during idle: actual %b expected 0", scan_en);
        end
      end
      src_valid = 1'b0;
      src_bit   = ~src_bit;
    end
    @(negedge clk);
    src_valid = 1'b1;
    src_bit   = b;
  endtask

  // Driver: flag then BLK data bits; expected outputs go into the scoreboard.
  task automatic send_block(input logic flag, input logic [BLK-1:0] data, input int gap);
    logic e;
    send_bit(flag, gap);
    for (int i = 0; i < BLK; i++) begin
      e = flag ? m_last : data[i];
      exp_bit_q.push_back(e);
      exp_tag_q.push_back(flag ? ((m_blk == 0) ? 6 : 4) : 3);
      pushed++;
      m_last = e;
      send_bit(data[i], gap);
    end
    m_blk++;
    if (m_blk == BPP) begin
      m_blk  = 0;
      m_last = 1'b0;
    end
  endtask

  task automatic send_rand_block(input int gap);
    logic f;
    logic [BLK-1:0] d;
    next_rand(f);
    for (int i = 0; i < BLK; i++) next_rand(d[i]);
    send_block(f, d, gap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (scan_en !== 1'b0 || scan_do !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual en=%b do=%b expected en=0 do=0", scan_en, scan_do);
    end
    rst = 1'b0;

    // Pattern A: first held block after reset shifts zeros (R1, R6), then R3 and R4 mix
    send_block(1'b1, 4'b1111, 0);
    send_block(1'b0, 4'b1101, 0);
    send_block(1'b1, 4'b0000, 0);   // R4: hold 1 while source sends zeros
    send_block(1'b0, 4'b1010, 0);   // last bit shifted is 1
    // Pattern B opens with a held block: must be zeros (R6)
    send_block(1'b1, 4'b1111, 0);
    send_block(1'b0, 4'b0110, 0);
    send_block(1'b1, 4'b1001, 0);   // R4: hold 0 while source toggles
    send_block(1'b0, 4'b1111, 0);
    // Pattern C with idle gaps (R7, R8)
    send_block(1'b0, 4'b0011, 2);
    send_block(1'b1, 4'b0101, 3);
    send_block(1'b0, 4'b1000, 1);
    send_block(1'b0, 4'b1001, 2);
    // Pattern D: held after a pattern ending in 1, with gaps (R6, R7)
    send_block(1'b1, 4'b1110, 2);
    send_block(1'b0, 4'b0001, 0);
    send_block(1'b1, 4'b0110, 1);
    send_block(1'b0, 4'b0101, 0);
    // Pseudo-random patterns (R3, R4, R5)
    for (int k = 0; k < 8 * BPP; k++) send_rand_block(k % 3);

    @(negedge clk);
    src_valid = 1'b0;
    repeat (4) @(negedge clk);

    // R5: every block produced exactly BLK pulses, none from flags
    checks++;
    if (exp_bit_q.size() != 0 || popped != pushed) begin
      errors++;
      $display("FAIL R5 shifted bit count: actual %0d expected %0d", popped, pushed);
    end
    // R5: decoder is back in flag phase - a held block now must still shift zeros
    send_block(1'b1, 4'b1111, 0);
    @(negedge clk);
    src_valid = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (exp_bit_q.size() != 0 || popped != pushed) begin
      errors++;
      $display("FAIL R5 final count: actual %0d expected %0d", popped, pushed);
    end
    finish_run();
  end
endmodule